// File: doc/BRIEF.md
# Parallel EEPROM Page-Write Sequencer

This block sits on the host side of a byte-wide parallel EEPROM and turns a burst of bytes into one or more page-write operations. A command carries the starting byte address. The bytes then arrive one at a time on a valid/ready stream, and the last one is flagged. For each byte the sequencer drives the address and data buses and pulses the write strobe low. All timing comes from cycle counts, which are computed from a clock-frequency parameter and the device's nanosecond, microsecond and millisecond limits. Each minimum is rounded up to whole cycles and the maximum byte-to-byte window is rounded down.

A page is closed in one of three cases. The burst ends. The next byte would fall outside the current page. Or the stream stalls so long that the next strobe would miss the maximum byte-to-byte window; in that case a sticky flag marks the page as cut short. After a page closes, chip enable and write strobe stay high and the data bus is released for the whole internal programming time. If the burst still has bytes left, they continue at the next address as a fresh page. When the burst is finished, `done` pulses for one cycle.

The controller has five states. `ST_IDLE` waits for a command: cmd accept goes to `ST_LOAD`. `ST_LOAD` waits for a byte: a byte accept goes to `ST_WE_LOW`, and a window timeout goes to `ST_PROGRAM`. `ST_WE_LOW` holds the strobe low: at the end of the pulse it goes to `ST_WE_HIGH`. `ST_WE_HIGH` pads the byte cycle: at the end of the padding it goes to `ST_PROGRAM` if that byte was the last of the burst or the last of its page, and otherwise back to `ST_LOAD`. `ST_PROGRAM` counts out the programming time: at the end it goes to `ST_IDLE` and pulses done if the burst is complete, and otherwise back to `ST_LOAD`.

Top module: `eeprom_page_writer`

## Requirements
- R1: While `rst` is high and after it, with no command pending, `ee_we_n`, `ee_ce_n` and `ee_oe_n` are 1, and `ee_dq_en`, `busy`, `done`, `page_cut` and `in_ready` are 0, and `cmd_ready` is 1.
- R2: Each accepted byte produces exactly one write-strobe low pulse of WP_CYC = ceil(200 ns x CLK_HZ) cycles. The byte's address and data appear in the cycle the strobe falls and stay unchanged while it is low.
- R3: Two strobe falls in the same page are never closer than BLC_MIN_CYC = ceil(400 ns x CLK_HZ) cycles. When the next byte is already waiting, the next fall comes exactly BLC_MIN_CYC cycles after the previous one.
- R4: Let BLC_MAX_CYC = floor(30 us x CLK_HZ). A byte that arrives so that its strobe falls at most BLC_MAX_CYC cycles after the previous fall continues the page. Otherwise the page closes, `ee_ce_n` rises exactly BLC_MAX_CYC cycles after the previous fall, and `page_cut` goes to 1. The remaining bytes then continue at the next address.
- R5: Address bits [ADDR_W-1:PAGE_BITS] select the page. A byte whose low PAGE_BITS bits are all ones closes the page when more bytes follow. The following byte goes to the next address, and its strobe falls one cycle after the programming wait ends.
- R6: When a page closes, the programming wait lasts WC_CYC = ceil(15 ms x CLK_HZ) cycles and starts BLC_MIN_CYC-1 cycles after that page's last strobe fall. Throughout the wait `ee_ce_n` and `ee_we_n` are 1, `ee_dq_en` is 0 and `in_ready` is 0.
- R7: `ee_oe_n` stays 1 at all times.
- R8: `done` is a one-cycle pulse seen BLC_MIN_CYC-1+WC_CYC cycles after the burst's final strobe fall. `busy` is 1 from the cycle after command accept until `done` rises, and `cmd_ready` returns with `done`.
- R9: `page_cut` keeps its value until the next command is accepted, which clears it.
- R10: `ee_ce_n` is 0 from a page's first strobe fall until the page closes, and covers every strobe low cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Start-of-burst request |
| cmd_addr | input | ADDR_W | First byte address of the burst |
| cmd_ready | output | 1 | Command can be taken (idle) |
| in_valid | input | 1 | Byte available on the stream |
| in_data | input | DATA_W | Byte value |
| in_last | input | 1 | Marks the final byte of the burst |
| in_ready | output | 1 | Byte is taken this cycle when valid |
| busy | output | 1 | Burst in progress |
| done | output | 1 | One-cycle pulse when the burst is fully programmed |
| page_cut | output | 1 | A page of this burst was closed by the window timeout |
| ee_addr | output | ADDR_W | Memory address bus |
| ee_dq_out | output | DATA_W | Memory data bus, driven value |
| ee_dq_en | output | 1 | Data bus drive enable |
| ee_ce_n | output | 1 | Chip enable, active low |
| ee_we_n | output | 1 | Write strobe, active low |
| ee_oe_n | output | 1 | Output enable, active low |

## Verification
The bench keeps CLK_HZ at 125 MHz with the default 200 ns and 400 ns limits, so the strobe is 25 cycles wide and the byte cycle is 50 cycles. It shortens T_BLC_MAX_NS to 2000 ns and T_WC_NS to 40000 ns, which gives a 250-cycle byte window and a 5000-cycle programming wait. With these values the window timeout, the exact-limit byte, a page crossing and several full programming waits all fit in a short run, and every edge can be checked to the exact cycle.

// File: rtl/eepw_pkg.sv
package eepw_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD,
        ST_WE_LOW,
        ST_WE_HIGH,
        ST_PROGRAM
    } eepw_state_e;

    // Minimum limit: round the cycle count up, never below one cycle.
    function automatic int unsigned cyc_ceil(longint unsigned t_ns, longint unsigned hz);
        longint unsigned c;
        c = (t_ns * hz + 64'd999_999_999) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

    // Maximum limit: round the cycle count down, never below one cycle.
    function automatic int unsigned cyc_floor(longint unsigned t_ns, longint unsigned hz);
        longint unsigned c;
        c = (t_ns * hz) / 64'd1_000_000_000;
        if (c == 64'd0) c = 64'd1;
        return c[31:0];
    endfunction

endpackage

// File: rtl/eepw_timer.sv
module eepw_timer #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)              cnt <= '0;
        else if (load)        cnt <= load_val;
        else if (cnt != '0)   cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/eepw_gap_mon.sv
module eepw_gap_mon #(
    parameter int unsigned LIMIT = 16,
    parameter int unsigned W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clear,
    input  logic         run,
    output logic [W-1:0] gap,
    output logic         last_slot
);
    always_ff @(posedge clk) begin
        if (rst)                        gap <= '0;
        else if (clear)                 gap <= '0;
        else if (run && (gap != '1))    gap <= gap + 1'b1;
    end

    // The next strobe fall may still be issued from this cycle, but not later.
    assign last_slot = (gap >= W'(LIMIT - 1));
endmodule

// File: rtl/eepw_page_ptr.sv
module eepw_page_ptr #(
    parameter int unsigned ADDR_W    = 15,
    parameter int unsigned PAGE_BITS = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic              advance,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              page_tail
);
    always_ff @(posedge clk) begin
        if (rst)          cur_addr <= '0;
        else if (load)    cur_addr <= load_addr;
        else if (advance) cur_addr <= cur_addr + 1'b1;
    end

    assign page_tail = &cur_addr[PAGE_BITS-1:0];
endmodule

// File: rtl/eeprom_page_writer.sv
module eeprom_page_writer #(
    parameter int unsigned CLK_HZ       = 125_000_000,
    parameter int unsigned ADDR_W       = 15,
    parameter int unsigned DATA_W       = 8,
    parameter int unsigned PAGE_BITS    = 6,
    parameter int unsigned T_WP_NS      = 200,
    parameter int unsigned T_BLC_MIN_NS = 400,
    parameter int unsigned T_BLC_MAX_NS = 30_000,
    parameter int unsigned T_WC_NS      = 15_000_000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_ready,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              busy,
    output logic              done,
    output logic              page_cut,
    output logic [ADDR_W-1:0] ee_addr,
    output logic [DATA_W-1:0] ee_dq_out,
    output logic              ee_dq_en,
    output logic              ee_ce_n,
    output logic              ee_we_n,
    output logic              ee_oe_n
);
    import eepw_pkg::*;

    localparam int unsigned WP_CYC      = cyc_ceil(64'(T_WP_NS), 64'(CLK_HZ));
    localparam int unsigned BLC_MIN_CYC = cyc_ceil(64'(T_BLC_MIN_NS), 64'(CLK_HZ));
    localparam int unsigned BLC_MAX_CYC = cyc_floor(64'(T_BLC_MAX_NS), 64'(CLK_HZ));
    localparam int unsigned WC_CYC      = cyc_ceil(64'(T_WC_NS), 64'(CLK_HZ));
    localparam int unsigned HOLD_CYC    = (BLC_MIN_CYC > WP_CYC + 1) ? (BLC_MIN_CYC - WP_CYC - 1) : 1;
    localparam int unsigned TMR_MAX_A   = (WC_CYC > WP_CYC) ? WC_CYC : WP_CYC;
    localparam int unsigned TMR_MAX     = (TMR_MAX_A > HOLD_CYC) ? TMR_MAX_A : HOLD_CYC;
    localparam int unsigned TW          = $clog2(TMR_MAX + 1);
    localparam int unsigned GW          = $clog2(BLC_MAX_CYC + 1);

    eepw_state_e state, state_nx;

    logic              tmr_load, tmr_expired;
    logic [TW-1:0]     tmr_val;
    logic [GW-1:0]     gap;
    logic              gap_last_slot;
    logic [ADDR_W-1:0] cur_addr;
    logic              page_tail;

    logic [ADDR_W-1:0] bus_addr;
    logic [DATA_W-1:0] bus_data;
    logic              page_open, last_r, tail_r, cut_r, done_r;

    logic cmd_take, accept, timeout, enter_prog;

    assign cmd_take   = (state == ST_IDLE) && cmd_valid;
    assign accept     = (state == ST_LOAD) && in_valid;
    assign timeout    = (state == ST_LOAD) && page_open && !in_valid && gap_last_slot;
    assign enter_prog = (state_nx == ST_PROGRAM) && (state != ST_PROGRAM);

    eepw_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    eepw_gap_mon #(.LIMIT(BLC_MAX_CYC), .W(GW)) u_gap (
        .clk       (clk),
        .rst       (rst),
        .clear     (accept),
        .run       (page_open),
        .gap       (gap),
        .last_slot (gap_last_slot)
    );

    eepw_page_ptr #(.ADDR_W(ADDR_W), .PAGE_BITS(PAGE_BITS)) u_ptr (
        .clk       (clk),
        .rst       (rst),
        .load      (cmd_take),
        .load_addr (cmd_addr),
        .advance   (accept),
        .cur_addr  (cur_addr),
        .page_tail (page_tail)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:    if (cmd_valid)   state_nx = ST_LOAD;
            ST_LOAD:    if (in_valid)    state_nx = ST_WE_LOW;
                        else if (timeout) state_nx = ST_PROGRAM;
            ST_WE_LOW:  if (tmr_expired) state_nx = ST_WE_HIGH;
            ST_WE_HIGH: if (tmr_expired) state_nx = (last_r || tail_r) ? ST_PROGRAM : ST_LOAD;
            ST_PROGRAM: if (tmr_expired) state_nx = last_r ? ST_IDLE : ST_LOAD;
            default:                     state_nx = ST_IDLE;
        endcase
    end

    // Interval timer is reloaded on entry to every timed state
    always_comb begin
        tmr_load = (state_nx != state);
        tmr_val  = '0;
        unique case (state_nx)
            ST_WE_LOW:  tmr_val = TW'(WP_CYC - 1);
            ST_WE_HIGH: tmr_val = TW'(HOLD_CYC - 1);
            ST_PROGRAM: tmr_val = TW'(WC_CYC - 1);
            default:    tmr_load = 1'b0;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= state_nx;
    end

    // Bus latches and burst flags
    always_ff @(posedge clk) begin
        if (rst) begin
            bus_addr  <= '0;
            bus_data  <= '0;
            page_open <= 1'b0;
            last_r    <= 1'b0;
            tail_r    <= 1'b0;
            cut_r     <= 1'b0;
            done_r    <= 1'b0;
        end else begin
            done_r <= (state == ST_PROGRAM) && (state_nx == ST_IDLE);
            if (cmd_take) begin
                cut_r  <= 1'b0;
                last_r <= 1'b0;
            end
            if (accept) begin
                bus_addr  <= cur_addr;
                bus_data  <= in_data;
                last_r    <= in_last;
                tail_r    <= page_tail;
                page_open <= 1'b1;
            end
            if (enter_prog) begin
                page_open <= 1'b0;
                if (timeout) cut_r <= 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        cmd_ready = (state == ST_IDLE);
        in_ready  = (state == ST_LOAD);
        busy      = (state != ST_IDLE);
        done      = done_r;
        page_cut  = cut_r;
        ee_addr   = bus_addr;
        ee_dq_out = bus_data;
        ee_dq_en  = page_open;
        ee_ce_n   = !page_open;
        ee_we_n   = (state != ST_WE_LOW);
        ee_oe_n   = 1'b1;
    end

    // Assertion support: run lengths of the strobe pulse and of the programming wait
    logic [TW-1:0] we_low_len, prog_len;
    always_ff @(posedge clk) begin
        if (rst) begin
            we_low_len <= '0;
            prog_len   <= '0;
        end else begin
            we_low_len <= ee_we_n ? '0 : we_low_len + 1'b1;
            prog_len   <= (state == ST_PROGRAM) ? prog_len + 1'b1 : '0;
        end
    end

    p_we_width_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(ee_we_n) |-> (we_low_len == TW'(WP_CYC)));

    p_bus_stable_r2: assert property (@(posedge clk) disable iff (rst)
        (!ee_we_n && $past(!ee_we_n)) |-> ($stable(ee_addr) && $stable(ee_dq_out)));

    p_min_spacing_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(ee_we_n) && $past(!ee_ce_n)) |-> ($past(gap) >= GW'(BLC_MIN_CYC - 1)));

    p_max_window_r4: assert property (@(posedge clk) disable iff (rst)
        !ee_ce_n |-> (gap < GW'(BLC_MAX_CYC)));

    p_same_page_r5: assert property (@(posedge clk) disable iff (rst)
        ($fell(ee_we_n) && $past(!ee_ce_n)) |->
        (ee_addr[ADDR_W-1:PAGE_BITS] == $past(ee_addr[ADDR_W-1:PAGE_BITS])));

    p_prog_len_r6: assert property (@(posedge clk) disable iff (rst)
        (($past(state) == ST_PROGRAM) && (state != ST_PROGRAM)) |-> (prog_len >= TW'(WC_CYC)));

    p_prog_quiet_r6: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PROGRAM) |-> (ee_ce_n && ee_we_n && !ee_dq_en && !in_ready));

    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && $past(busy)));

    p_ce_covers_we_r10: assert property (@(posedge clk) disable iff (rst)
        !ee_we_n |-> !ee_ce_n);
endmodule

// File: tb/eeprom_page_writer_tb.sv
`timescale 1ns/1ps
module eeprom_page_writer_tb;
    localparam int WP   = 25;
    localparam int BMIN = 50;
    localparam int BMAX = 250;
    localparam int WC   = 5000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [14:0] cmd_addr = '0;
    logic        cmd_ready;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_last = 1'b0;
    logic        in_ready, busy, done, page_cut;
    logic [14:0] ee_addr;
    logic [7:0]  ee_dq_out;
    logic        ee_dq_en, ee_ce_n, ee_we_n, ee_oe_n;

    always #4 clk = ~clk;

    eeprom_page_writer #(
        .CLK_HZ(125_000_000), .ADDR_W(15), .DATA_W(8), .PAGE_BITS(6),
        .T_WP_NS(200), .T_BLC_MIN_NS(400), .T_BLC_MAX_NS(2000), .T_WC_NS(40000)
    ) u_dut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr), .cmd_ready(cmd_ready),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last), .in_ready(in_ready),
        .busy(busy), .done(done), .page_cut(page_cut), .ee_addr(ee_addr), .ee_dq_out(ee_dq_out),
        .ee_dq_en(ee_dq_en), .ee_ce_n(ee_ce_n), .ee_we_n(ee_we_n), .ee_oe_n(ee_oe_n)
    );

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Bus monitor, sampled mid-cycle
    int          nf, nr, nc, ndone, unstable, oe_bad, done_cyc;
    int          fall_cyc [0:127];
    logic [14:0] fall_addr[0:127];
    logic [7:0]  fall_data[0:127];
    logic        fall_ce  [0:127];
    int          low_w    [0:127];
    int          ce_rise  [0:15];
    logic        prev_we = 1'b1, prev_ce = 1'b1;

    always @(negedge clk) begin
        if (!rst) begin
            if (prev_we && !ee_we_n && nf < 128) begin
                fall_cyc[nf] = cyc; fall_addr[nf] = ee_addr;
                fall_data[nf] = ee_dq_out; fall_ce[nf] = ee_ce_n; nf++;
            end else if (!ee_we_n && nf > 0) begin
                if (ee_addr != fall_addr[nf-1] || ee_dq_out != fall_data[nf-1]) unstable++;
            end
            if (!prev_we && ee_we_n && nf > 0 && nr < 128) begin
                low_w[nr] = cyc - fall_cyc[nf-1]; nr++;
            end
            if (!prev_ce && ee_ce_n && nc < 16) begin ce_rise[nc] = cyc; nc++; end
            if (done) begin done_cyc = cyc; ndone++; end
            if (!ee_oe_n) oe_bad++;
            prev_we = ee_we_n;
            prev_ce = ee_ce_n;
        end
    end

    task automatic clear_log();
        nf = 0; nr = 0; nc = 0; ndone = 0; unstable = 0; oe_bad = 0; done_cyc = 0;
    endtask

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic start_cmd(input logic [14:0] a);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_addr = a;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // Called at a falling edge; returns at the falling edge after the byte is taken.
    task automatic push(input logic [7:0] d, input bit last);
        in_valid = 1'b1; in_data = d; in_last = last;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0; in_last = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
        check(busy == 1'b0, "R8", "busy with done", busy, 0);
        check(cmd_ready == 1'b1, "R8", "cmd_ready with done", cmd_ready, 1);
        @(negedge clk);
        check(done == 1'b0, "R8", "done pulse width", done, 0);
    endtask

    task automatic t_reset();
        check(ee_we_n && ee_ce_n && ee_oe_n, "R1", "controls in reset",
              {ee_we_n, ee_ce_n, ee_oe_n}, 7);
        check(!ee_dq_en && !busy && !done && !page_cut && !in_ready && cmd_ready, "R1",
              "status in reset", {ee_dq_en, busy, done, page_cut, in_ready, cmd_ready}, 1);
    endtask

    task automatic t_basic();
        clear_log();
        start_cmd(15'h0105);
        check(busy == 1'b1, "R8", "busy after command", busy, 1);
        for (int i = 0; i < 4; i++) push(8'hA0 + 8'(i), i == 3);
        repeat (100) @(negedge clk);
        check(!in_ready && busy && !ee_dq_en && ee_ce_n && ee_we_n, "R6", "quiet during wait",
              {in_ready, busy, ee_dq_en, ee_ce_n, ee_we_n}, 5'b01011);
        wait_done();
        check(nf == 4, "R2", "strobe count", nf, 4);
        for (int i = 0; i < 4; i++) begin
            check(fall_addr[i] == 15'h0105 + 15'(i), "R2", "address", fall_addr[i], 15'h0105 + i);
            check(fall_data[i] == 8'hA0 + 8'(i), "R2", "data", fall_data[i], 8'hA0 + i);
            check(low_w[i] == WP, "R2", "strobe width", low_w[i], WP);
            check(fall_ce[i] == 1'b0, "R10", "ce at strobe", fall_ce[i], 0);
        end
        for (int i = 0; i < 3; i++)
            check(fall_cyc[i+1] - fall_cyc[i] == BMIN, "R3", "byte spacing",
                  fall_cyc[i+1] - fall_cyc[i], BMIN);
        check(unstable == 0, "R2", "bus stable while low", unstable, 0);
        check(nc == 1, "R10", "ce rises once", nc, 1);
        check(ce_rise[0] - fall_cyc[3] == BMIN - 1, "R10", "ce release", ce_rise[0] - fall_cyc[3], BMIN - 1);
        check(done_cyc - fall_cyc[3] == BMIN - 1 + WC, "R6", "done after wait",
              done_cyc - fall_cyc[3], BMIN - 1 + WC);
        check(ndone == 1, "R8", "done count", ndone, 1);
        check(page_cut == 1'b0, "R4", "no cut", page_cut, 0);
        check(oe_bad == 0, "R7", "oe stays high", oe_bad, 0);
    endtask

    task automatic t_cross();
        clear_log();
        start_cmd(15'h023E);
        for (int i = 0; i < 4; i++) push(8'h30 + 8'(i), i == 3);
        wait_done();
        check(nf == 4, "R5", "strobe count", nf, 4);
        check(fall_addr[1] == 15'h023F && fall_addr[2] == 15'h0240 && fall_addr[3] == 15'h0241,
              "R5", "addresses across page", fall_addr[2], 15'h0240);
        check(fall_cyc[1] - fall_cyc[0] == BMIN, "R3", "spacing in page", fall_cyc[1] - fall_cyc[0], BMIN);
        check(fall_cyc[2] - fall_cyc[1] == BMIN + WC, "R5", "new page after wait",
              fall_cyc[2] - fall_cyc[1], BMIN + WC);
        check(nc == 2 && ce_rise[0] - fall_cyc[1] == BMIN - 1, "R5", "first page close",
              ce_rise[0] - fall_cyc[1], BMIN - 1);
        check(fall_data[2] == 8'h32, "R5", "data after crossing", fall_data[2], 8'h32);
        check(page_cut == 1'b0, "R5", "crossing is not a cut", page_cut, 0);
    endtask

    task automatic t_stall();
        clear_log();
        start_cmd(15'h0410);
        push(8'h51, 1'b0);
        push(8'h52, 1'b0);
        repeat (400) @(negedge clk);
        check(page_cut == 1'b1, "R4", "cut flag", page_cut, 1);
        check(ee_ce_n == 1'b1 && busy, "R4", "page closed on stall", ee_ce_n, 1);
        push(8'h53, 1'b1);
        wait_done();
        check(ce_rise[0] - fall_cyc[1] == BMAX, "R4", "close time", ce_rise[0] - fall_cyc[1], BMAX);
        check(fall_cyc[2] - fall_cyc[1] == BMAX + WC + 1, "R4", "resume after wait",
              fall_cyc[2] - fall_cyc[1], BMAX + WC + 1);
        check(fall_addr[2] == 15'h0412, "R4", "resume address", fall_addr[2], 15'h0412);
        repeat (20) @(negedge clk);
        check(page_cut == 1'b1, "R9", "cut flag held", page_cut, 1);
    endtask

    task automatic t_window();
        clear_log();
        start_cmd(15'h0600);
        check(page_cut == 1'b0, "R9", "cut cleared by command", page_cut, 0);
        push(8'h61, 1'b0);
        @(negedge clk);
        while (cyc < fall_cyc[0] + BMAX - 1) @(negedge clk);
        push(8'h62, 1'b1);
        wait_done();
        check(nf == 2 && fall_cyc[1] - fall_cyc[0] == BMAX, "R4", "byte at window limit",
              fall_cyc[1] - fall_cyc[0], BMAX);
        check(nc == 1 && page_cut == 1'b0, "R4", "page kept open", page_cut, 0);
        check(ce_rise[0] - fall_cyc[1] == BMIN - 1, "R10", "ce release", ce_rise[0] - fall_cyc[1], BMIN - 1);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst = 1'b0;
        repeat (3) @(negedge clk);
        t_reset();
        t_basic();
        t_cross();
        t_stall();
        t_window();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule